// File: doc/BRIEF.md
# UART Status Flag and Interrupt Request Controller

This block keeps the status flags of a UART that can also run a LIN bus, and turns them into interrupt requests. The receiver, the transmitter and the break detector report events as single-cycle strobes. A bus decoder reports software accesses as single-cycle strobes. From both the block keeps six flags: receive buffer full, overrun, framing error, parity error, transmit buffer empty and break detected. It also holds the received character.

Three request lines leave the block: receive, transmit and break. Each one is gated by its own enable input. Every flag has its own way of being cleared. The receive-full flag clears when the receive buffer is read. The three error flags clear together when a shared clear bit is written with 1. Transmit-empty clears when a new character is written. The break flag clears when a 0 is written to it. When a set and a clear hit the same flag in the same cycle, the set wins.

Top module: `uart_irq_flags`

## Requirements
- R1: After a synchronous reset, `tx_empty` is 1. Every other flag, `rx_data_q` and all three request lines are 0.
- R2: A character is accepted when `rx_char_done` pulses while `rx_full` is 0, or in the same cycle as `rd_rxbuf`. On the next cycle `rx_full` is 1 and `rx_data_q` holds that character. A `rd_rxbuf` with no character arriving clears `rx_full`.
- R3: A character that completes while `rx_full` is 1 and no read happens in that cycle sets `ovr_err` and is discarded. `rx_data_q` and `rx_full` keep their values.
- R4: `frm_err` and `par_err` set from `rx_frame_err` and `rx_parity_err` only for an accepted character. The error inputs of a discarded character have no effect.
- R5: A `wr_err_clr` pulse clears `ovr_err`, `frm_err` and `par_err` together. An error set in the same cycle wins over the clear.
- R6: `tx_load` sets `tx_empty` and `wr_txbuf` clears it. When both arrive in the same cycle, `tx_empty` ends up 1.
- R7: `brk_det` sets `brk_flag` only while `mode` is 2'b11 (LIN). With `mode` at 2'b00, 2'b01 or 2'b10 it has no effect.
- R8: `wr_brk` with `wr_brk_val`=0 clears `brk_flag`. With `wr_brk_val`=1 it has no effect. A break detected in the same cycle wins over the clear.
- R9: `irq_rx` is 1 exactly when `rx_ie` is 1 and at least one of `rx_full`, `ovr_err`, `frm_err`, `par_err` is 1.
- R10: `irq_tx` is 1 exactly when `tx_ie` is 1 and `tx_empty` is 1.
- R11: `irq_brk` is 1 exactly when `brk_ie` is 1 and `brk_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode; 2'b11 is LIN |
| rx_ie | input | 1 | Receive request enable |
| tx_ie | input | 1 | Transmit request enable |
| brk_ie | input | 1 | Break request enable |
| rx_char_done | input | 1 | Receiver finished a character |
| rx_char | input | DATA_W | Character from the receiver |
| rx_frame_err | input | 1 | Framing error of this character |
| rx_parity_err | input | 1 | Parity error of this character |
| tx_load | input | 1 | Transmit buffer moved to the shifter |
| brk_det | input | 1 | Break detector fired |
| rd_rxbuf | input | 1 | Software reads the receive buffer |
| wr_txbuf | input | 1 | Software writes the transmit buffer |
| wr_err_clr | input | 1 | Software writes 1 to the error-clear bit |
| wr_brk | input | 1 | Software writes the break flag |
| wr_brk_val | input | 1 | Value written to the break flag |
| rx_full | output | 1 | Receive buffer holds a character |
| rx_data_q | output | DATA_W | Received character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| tx_empty | output | 1 | Transmit buffer empty flag |
| brk_flag | output | 1 | Break detected flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The bench builds the block with `DATA_W` = 6, a width other than the default. With a 6-bit character the test values reach the top bit of the receive buffer, and the bench can tell a discarded character from a kept one by its value. The only parameter is the data width, so every flag path is reached whatever width is chosen. The stimulus therefore walks the four modes and covers each same-cycle collision of a set and a clear.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_MULTI = 2'b01,
        MODE_SYNC  = 2'b10,
        MODE_LIN   = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic full;
        logic ovr;
        logic frm;
        logic par;
    } rx_flags_t;

    // next value of a sticky flag: a set always beats a clear
    function automatic logic flag_next(input logic q, input logic set, input logic clr);
        return set | (q & ~clr);
    endfunction

endpackage

// File: rtl/uart_flag_bit.sv
module uart_flag_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    import uart_flag_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= flag_next(q, set, clr);
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_in,
    input  logic              frame_err,
    input  logic              parity_err,
    input  logic              rd_buf,
    input  logic              err_clr,
    output uart_flag_pkg::rx_flags_t flags,
    output logic [DATA_W-1:0] data_q
);
    import uart_flag_pkg::*;

    logic accept;
    logic overrun;

    // a read in the same cycle frees the buffer for the incoming character
    assign accept  = char_done & (~flags.full | rd_buf);
    assign overrun = char_done & flags.full & ~rd_buf;

    uart_flag_bit #(.RST_VAL(1'b0)) u_full (
        .clk(clk), .rst(rst), .set(accept), .clr(rd_buf), .q(flags.full));
    uart_flag_bit #(.RST_VAL(1'b0)) u_ovr (
        .clk(clk), .rst(rst), .set(overrun), .clr(err_clr), .q(flags.ovr));
    uart_flag_bit #(.RST_VAL(1'b0)) u_frm (
        .clk(clk), .rst(rst), .set(accept & frame_err), .clr(err_clr), .q(flags.frm));
    uart_flag_bit #(.RST_VAL(1'b0)) u_par (
        .clk(clk), .rst(rst), .set(accept & parity_err), .clr(err_clr), .q(flags.par));

    always_ff @(posedge clk) begin
        if (rst)         data_q <= '0;
        else if (accept) data_q <= char_in;
    end

    p_accept_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (char_done && (!flags.full || rd_buf)) |=> (flags.full && data_q == $past(char_in)));

    p_overrun_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (char_done && flags.full && !rd_buf) |=> (flags.ovr && flags.full && $stable(data_q)));

    p_frame_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && frame_err) |=> flags.frm);

    p_err_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !char_done) |=> (!flags.ovr && !flags.frm && !flags.par));

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
    input  uart_flag_pkg::rx_flags_t rx_flags,
    input  logic tx_empty,
    input  logic brk_flag,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic brk_ie,
    output logic irq_rx,
    output logic irq_tx,
    output logic irq_brk
);
    import uart_flag_pkg::*;

    always_comb begin
        irq_rx  = rx_ie & (|rx_flags);
        irq_tx  = tx_ie & tx_empty;
        irq_brk = brk_ie & brk_flag;
    end

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic              brk_ie,
    input  logic              rx_char_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              tx_load,
    input  logic              brk_det,
    input  logic              rd_rxbuf,
    input  logic              wr_txbuf,
    input  logic              wr_err_clr,
    input  logic              wr_brk,
    input  logic              wr_brk_val,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data_q,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              tx_empty,
    output logic              brk_flag,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_brk
);
    import uart_flag_pkg::*;

    op_mode_e  mode_e;
    rx_flags_t rx_flags;
    logic      lin_on;
    logic      brk_set;
    logic      brk_clr;

    assign mode_e  = op_mode_e'(mode);
    assign lin_on  = (mode_e == MODE_LIN);
    assign brk_set = brk_det & lin_on;
    assign brk_clr = wr_brk & ~wr_brk_val;

    uart_rx_status #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst),
        .char_done(rx_char_done), .char_in(rx_char),
        .frame_err(rx_frame_err), .parity_err(rx_parity_err),
        .rd_buf(rd_rxbuf), .err_clr(wr_err_clr),
        .flags(rx_flags), .data_q(rx_data_q));

    uart_flag_bit #(.RST_VAL(1'b1)) u_txe (
        .clk(clk), .rst(rst), .set(tx_load), .clr(wr_txbuf), .q(tx_empty));

    uart_flag_bit #(.RST_VAL(1'b0)) u_brk (
        .clk(clk), .rst(rst), .set(brk_set), .clr(brk_clr), .q(brk_flag));

    uart_irq_gen u_irq (
        .rx_flags(rx_flags), .tx_empty(tx_empty), .brk_flag(brk_flag),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .brk_ie(brk_ie),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_brk(irq_brk));

    assign rx_full = rx_flags.full;
    assign ovr_err = rx_flags.ovr;
    assign frm_err = rx_flags.frm;
    assign par_err = rx_flags.par;

    p_tx_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> tx_empty);

    p_tx_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_txbuf && !tx_load) |=> !tx_empty);

    p_brk_mode_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b11 && !brk_flag) |=> !brk_flag);

    p_brk_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_brk && !wr_brk_val && !(brk_det && mode == 2'b11)) |=> !brk_flag);

    p_brk_write1_r8: assert property (@(posedge clk) disable iff (rst)
        (brk_flag && wr_brk && wr_brk_val) |=> brk_flag);

endmodule

// File: tb/tb_uart_irq_flags.sv
module tb_uart_irq_flags;
    localparam int DW = 6;
    localparam int VW = DW + 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic rx_ie = 0, tx_ie = 0, brk_ie = 0;
    logic rx_char_done = 0, rx_frame_err = 0, rx_parity_err = 0;
    logic [DW-1:0] rx_char = '0;
    logic tx_load = 0, brk_det = 0, rd_rxbuf = 0, wr_txbuf = 0;
    logic wr_err_clr = 0, wr_brk = 0, wr_brk_val = 0;
    logic rx_full, ovr_err, frm_err, par_err, tx_empty, brk_flag;
    logic irq_rx, irq_tx, irq_brk;
    logic [DW-1:0] rx_data_q;

    always #5 clk = ~clk;

    uart_irq_flags #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .mode(mode),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .brk_ie(brk_ie),
        .rx_char_done(rx_char_done), .rx_char(rx_char),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .tx_load(tx_load), .brk_det(brk_det),
        .rd_rxbuf(rd_rxbuf), .wr_txbuf(wr_txbuf), .wr_err_clr(wr_err_clr),
        .wr_brk(wr_brk), .wr_brk_val(wr_brk_val),
        .rx_full(rx_full), .rx_data_q(rx_data_q),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
        .tx_empty(tx_empty), .brk_flag(brk_flag),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_brk(irq_brk));

    // reference model state, written from the requirements
    logic m_full = 0, m_ovr = 0, m_frm = 0, m_par = 0, m_txe = 1, m_brk = 0;
    logic [DW-1:0] m_data = '0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic logic [VW-1:0] pack_exp();
        logic irx, itx, ibk;
        irx = rx_ie & (m_full | m_ovr | m_frm | m_par);
        itx = tx_ie & m_txe;
        ibk = brk_ie & m_brk;
        return {m_full, m_ovr, m_frm, m_par, m_txe, m_brk, irx, itx, ibk, m_data};
    endfunction

    // driver: model the coming edge, queue the expected outputs, clock, release strobes
    task automatic tick(input string tag);
        logic acc, ovf, bset, bclr;
        acc  = rx_char_done & (~m_full | rd_rxbuf);
        ovf  = rx_char_done & m_full & ~rd_rxbuf;
        bset = brk_det & (mode == 2'b11);
        bclr = wr_brk & ~wr_brk_val;
        m_ovr  = ovf | (m_ovr & ~wr_err_clr);
        m_frm  = (acc & rx_frame_err)  | (m_frm & ~wr_err_clr);
        m_par  = (acc & rx_parity_err) | (m_par & ~wr_err_clr);
        if (acc) m_data = rx_char;
        m_full = acc | (m_full & ~rd_rxbuf);
        m_txe  = tx_load | (m_txe & ~wr_txbuf);
        m_brk  = bset | (m_brk & ~bclr);
        exp_q.push_back(pack_exp());
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        rx_char_done = 0; rx_frame_err = 0; rx_parity_err = 0;
        tx_load = 0; brk_det = 0; rd_rxbuf = 0; wr_txbuf = 0;
        wr_err_clr = 0; wr_brk = 0; wr_brk_val = 0;
    endtask

    // monitor: compare after each edge that has a queued expectation
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [VW-1:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {rx_full, ovr_err, frm_err, par_err, tx_empty, brk_flag,
                 irq_rx, irq_tx, irq_brk, rx_data_q};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s actual=%b expected=%b", t, a, e);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tick("R1 reset values");
        tx_ie = 1;
        tick("R10 irq_tx follows tx_empty");
        wr_txbuf = 1;
        tick("R6 write clears tx_empty, R10 irq_tx drops");
        tx_load = 1;
        tick("R6 load sets tx_empty");
        tx_load = 1; wr_txbuf = 1;
        tick("R6 set beats clear");
        rx_char_done = 1; rx_char = 6'h25;
        tick("R2 first character accepted, R9 disabled");
        rx_ie = 1;
        tick("R9 irq_rx with rx_full");
        rx_char_done = 1; rx_char = 6'h2A; rx_frame_err = 1; rx_parity_err = 1;
        tick("R3 overrun keeps data, R4 discarded errors ignored");
        rd_rxbuf = 1;
        tick("R2 read clears rx_full, R9 overrun still requests");
        wr_err_clr = 1;
        tick("R5 clear drops overrun, R9 no request");
        rx_char_done = 1; rx_char = 6'h3F; rx_frame_err = 1; rx_parity_err = 1;
        tick("R4 errors of accepted character");
        rx_char_done = 1; rx_char = 6'h12; rd_rxbuf = 1;
        tick("R2 read and arrival same cycle, no overrun");
        rd_rxbuf = 1; rx_char_done = 1; rx_char = 6'h01; rx_frame_err = 1; wr_err_clr = 1;
        tick("R5 framing set beats clear, parity cleared");
        wr_err_clr = 1; rd_rxbuf = 1;
        tick("R5 clear all, R9 quiet");
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m); brk_det = 1;
            tick("R7 break ignored outside LIN");
        end
        mode = 2'b11; brk_det = 1;
        tick("R7 break sets in LIN, R11 disabled");
        brk_ie = 1;
        tick("R11 irq_brk");
        wr_brk = 1; wr_brk_val = 1;
        tick("R8 write 1 no effect");
        wr_brk = 1; wr_brk_val = 0;
        tick("R8 write 0 clears, R11 drops");
        brk_det = 1; wr_brk = 1; wr_brk_val = 0;
        tick("R8 detect beats clear");
        tx_ie = 0; rx_ie = 0; brk_ie = 0;
        tick("R9 R10 R11 all gated off");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule